// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns four asynchronous external interrupt pins into interrupt request flags. Every pin first passes through a synchronizer. Pin 0 then goes through a noise filter, and after that each pin reaches an edge detector. The triggering edge of each configurable pin is chosen by small mode registers that the CPU writes with 4-bit write operations. The filter on pin 0 samples either on every CPU clock or only on the cycles marked by a clock-enable pulse that an external divide-by-64 divider supplies.

The pins have fixed roles. Pin 0 is the filtered pin, with a two-bit edge code. Pin 1 has a rising or falling choice. Pin 2 is a quasi-interrupt that also has a rising or falling choice, but its flag is removed only by an explicit software clear. Pin 3 always triggers on both edges. Each flag can be cleared by the CPU through `flag_clr`. The flags of pins 0, 1 and 3 can also be cleared by the acknowledge pulse from the interrupt controller (`irq_ack`). Priority, the master enable and vectoring belong to the surrounding interrupt logic.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset all request flags are 0 and every mode register holds zero, so pins 0, 1 and 2 trigger on rising edges until they are written.
- R2: On pins 1, 2 and 3, a level change driven before clock edge 1 produces no flag after edge 2 and sets the flag on edge 3 (two synchronizer flops, then the flag register).
- R3: Mode register 0 (write select 0) bits [1:0] set the edge for pin 0: 00 rising, 01 falling, 10 both edges.
- R4: Code 11 in mode register 0 bits [1:0] never lets the pin 0 flag be set.
- R5: The pin 0 filter takes a new level only when three consecutive samples agree. A pulse that covers two samples raises no request, and one that covers three does.
- R6: Mode register 0 bit 3 selects the filter sampling: 0 samples on every clock, 1 samples only on cycles where `div_tick` is high.
- R7: Mode register 1 (write select 1) bit 0 sets the edge for pin 1: 0 rising, 1 falling.
- R8: Mode register 2 (write select 2) bit 0 sets the edge for pin 2: 0 rising, 1 falling. The pin 2 flag ignores `irq_ack` and is cleared only by `flag_clr[2]`.
- R9: Pin 3 sets its flag on both rising and falling edges, whatever the contents of the mode registers.
- R10: `flag_clr[i]` clears flag i on the next edge. `irq_ack[i]` does the same for pins 0, 1 and 3. A new edge in the same cycle as a clear leaves the flag set.
- R11: Writing a mode register never raises a request by itself, because the stored previous level keeps tracking the pin in every mode.
- R12: A write with select value 3 changes no mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_tick | input | 1 | One-cycle pulse from the divide-by-64 clock divider |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Mode register write strobe |
| wr_sel | input | 2 | Mode register select (0, 1, 2; 3 unused) |
| wr_data | input | 4 | Mode register write data |
| flag_clr | input | 4 | Per-pin software flag clear |
| irq_ack | input | 4 | Per-pin acknowledge from the interrupt controller |
| irq_flag | output | 4 | Per-pin interrupt request flags |

## Verification
The bench measures the exact synchronizer latency. A design with one flop too many or too few sets the flag a cycle off. It sends glitches of two and three samples into the filter, and a short pulse in divided-sample mode that a filter stuck on the CPU clock would wrongly accept. It lines up a clear with a new edge in the same cycle, where a design that gives the clear priority loses a request. It also pulses acknowledge on the quasi-interrupt pin, which a shared clear path would wrongly empty, and it rewrites edge codes under a steady pin, where a detector that freezes its previous level raises a spurious request.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_OFF  = 2'b11
   } edge_sel_e;

   localparam int NUM_PINS  = 4;
   localparam int PIN_FILT  = 0;
   localparam int PIN_SEL   = 1;
   localparam int PIN_QUASI = 2;
   localparam int PIN_BOTH  = 3;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eirq_filter.sv
module eirq_filter #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("eirq_filter: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-2:0] hist;
   logic [DEPTH-1:0] window;

   assign window = {hist, d};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist <= '0;
         q    <= 1'b0;
      end else if (en) begin
         hist <= window[DEPTH-2:0];
         if (&window)       q <= 1'b1;
         else if (~|window) q <= 1'b0;
      end
   end

   // R6
   filt_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> $past(en));
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge
   import eirq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  edge_sel_e mode,
   output logic      det
);
   logic prev;
   logic rise;
   logic fall;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      unique case (mode)
         EDGE_RISE: det = rise;
         EDGE_FALL: det = fall;
         EDGE_BOTH: det = rise | fall;
         default:   det = 1'b0;
      endcase
   end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import eirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 3,
   parameter int WR_W        = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                div_tick,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [WR_W-1:0]     wr_data,
   input  logic [NUM_PINS-1:0] flag_clr,
   input  logic [NUM_PINS-1:0] irq_ack,
   output logic [NUM_PINS-1:0] irq_flag
);
   localparam logic [NUM_PINS-1:0] QUASI_MASK = NUM_PINS'(1) << PIN_QUASI;
   localparam int SLOW_BIT = 3;

   generate
      if (WR_W < SLOW_BIT + 1) begin : g_bad_width
         $error("ext_irq_detect: WR_W too narrow for the sample-select bit");
      end
   endgenerate

   edge_sel_e m0_edge;
   logic      m0_slow;
   logic      m1_fall;
   logic      m2_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m0_edge <= EDGE_RISE;
         m0_slow <= 1'b0;
         m1_fall <= 1'b0;
         m2_fall <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            2'd0: begin
               m0_edge <= edge_sel_e'(wr_data[1:0]);
               m0_slow <= wr_data[SLOW_BIT];
            end
            2'd1:    m1_fall <= wr_data[0];
            2'd2:    m2_fall <= wr_data[0];
            default: ;
         endcase
      end
   end

   edge_sel_e mode_v [NUM_PINS];
   logic [NUM_PINS-1:0] sync_lvl;
   logic [NUM_PINS-1:0] edge_lvl;
   logic [NUM_PINS-1:0] set_v;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pin_in[gi]), .q(sync_lvl[gi]));

         if (gi == PIN_FILT) begin : g_filt
            eirq_filter #(.DEPTH(FILT_DEPTH)) u_filt (
               .clk(clk), .rst_n(rst_n),
               .en(m0_slow ? div_tick : 1'b1),
               .d(sync_lvl[gi]), .q(edge_lvl[gi]));
            assign mode_v[gi] = m0_edge;
         end else begin : g_raw
            assign edge_lvl[gi] = sync_lvl[gi];
            if (gi == PIN_BOTH) begin : g_both
               assign mode_v[gi] = EDGE_BOTH;
            end else if (gi == PIN_QUASI) begin : g_quasi
               assign mode_v[gi] = m2_fall ? EDGE_FALL : EDGE_RISE;
            end else begin : g_sel
               assign mode_v[gi] = m1_fall ? EDGE_FALL : EDGE_RISE;
            end
         end

         eirq_edge u_edge (
            .clk(clk), .rst_n(rst_n), .lvl(edge_lvl[gi]),
            .mode(mode_v[gi]), .det(set_v[gi]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) irq_flag <= '0;
      else        irq_flag <= set_v | (irq_flag & ~flag_clr & ~(irq_ack & ~QUASI_MASK));
   end

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> ((irq_flag & $past(set_v)) == $past(set_v)));

   // R10
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_clr & ~set_v) != '0) |=> ((irq_flag & $past(flag_clr & ~set_v)) == '0));

   // R8
   quasi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[PIN_QUASI] && !flag_clr[PIN_QUASI]) |=> irq_flag[PIN_QUASI]);

   // R4
   off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m0_edge == EDGE_OFF) |-> !set_v[PIN_FILT]);
endmodule

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_tick = 1'b0;
   logic [3:0] pin_in = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [3:0] wr_data = '0;
   logic [3:0] flag_clr = '0;
   logic [3:0] irq_ack = '0;
   logic [3:0] irq_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int tick_cnt = 0;

   always #2.5 clk = ~clk;

   ext_irq_detect uut (
      .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .pin_in(pin_in),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .flag_clr(flag_clr), .irq_ack(irq_ack), .irq_flag(irq_flag));

   // divided sampling pulse, one cycle in eight
   always @(negedge clk) begin
      tick_cnt <= tick_cnt + 1;
      div_tick <= ((tick_cnt % 8) == 0);
   end

   // vector: {pin, wr_sel, mode data, start level, end level, flag expected}
   localparam int NV = 16;
   localparam logic [10:0] VEC [NV] = '{
      {2'd0, 2'd0, 4'd0, 1'b0, 1'b1, 1'b1},   // R3 rising
      {2'd0, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0},   // R3
      {2'd0, 2'd0, 4'd1, 1'b0, 1'b1, 1'b0},   // R3 falling
      {2'd0, 2'd0, 4'd1, 1'b1, 1'b0, 1'b1},   // R3
      {2'd0, 2'd0, 4'd2, 1'b0, 1'b1, 1'b1},   // R3 both
      {2'd0, 2'd0, 4'd2, 1'b1, 1'b0, 1'b1},   // R3
      {2'd0, 2'd0, 4'd3, 1'b0, 1'b1, 1'b0},   // R4 disabled
      {2'd0, 2'd0, 4'd3, 1'b1, 1'b0, 1'b0},   // R4
      {2'd1, 2'd1, 4'd0, 1'b0, 1'b1, 1'b1},   // R7 rising
      {2'd1, 2'd1, 4'd1, 1'b0, 1'b1, 1'b0},   // R7 falling
      {2'd1, 2'd1, 4'd1, 1'b1, 1'b0, 1'b1},   // R7
      {2'd2, 2'd2, 4'd0, 1'b0, 1'b1, 1'b1},   // R8 rising
      {2'd2, 2'd2, 4'd1, 1'b0, 1'b1, 1'b0},   // R8 falling
      {2'd2, 2'd2, 4'd1, 1'b1, 1'b0, 1'b1},   // R8
      {2'd3, 2'd3, 4'd0, 1'b0, 1'b1, 1'b1},   // R9 both, fixed
      {2'd3, 2'd3, 4'd0, 1'b1, 1'b0, 1'b1}    // R9
   };
   localparam int VREQ [NV] = '{3, 3, 3, 3, 3, 3, 4, 4, 7, 7, 7, 8, 8, 8, 9, 9};

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq_flag=%b expected %b", req, act, exp);
      end
   endtask

   task automatic write_mode(input logic [1:0] sel, input logic [3:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic clear_all();
      flag_clr = 4'hF;
      step(1);
      flag_clr = 4'h0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R1 reset flags", irq_flag, 4'b0000);

      // R1 default rising on pin 1, R2 exact latency
      pin_in[1] = 1'b1;
      step(2);
      check("R2 no flag after edge 2", irq_flag, 4'b0000);
      step(1);
      check("R2 flag on edge 3 (R1 default rising)", irq_flag, 4'b0010);
      clear_all();
      step(1);

      for (int v = 0; v < NV; v++) begin
         automatic int pin = int'(VEC[v][10:9]);
         write_mode(VEC[v][8:7], VEC[v][6:3]);
         pin_in[pin] = VEC[v][2];
         step(12);
         clear_all();
         step(1);
         pin_in[pin] = VEC[v][1];
         step(12);
         check($sformatf("R%0d vector %0d", VREQ[v], v), irq_flag,
               VEC[v][0] ? (4'b0001 << pin) : 4'b0000);
         clear_all();
      end

      // R10 set wins over clear in the same cycle; ack clears pin 1
      pin_in[1] = 1'b1;            // mode 1 is falling: no request
      step(12);
      clear_all();
      pin_in[1] = 1'b0;
      step(2);
      flag_clr = 4'b0010;
      step(1);
      check("R10 set beats clear", irq_flag, 4'b0010);
      flag_clr = 4'b0000;
      step(1);
      check("R10 flag held", irq_flag, 4'b0010);
      irq_ack = 4'b0010;
      step(1);
      irq_ack = 4'b0000;
      check("R10 ack clears pin 1", irq_flag, 4'b0000);

      // R8 quasi pin ignores acknowledge
      pin_in[2] = 1'b1;
      step(12);
      pin_in[2] = 1'b0;            // mode 2 is falling
      step(12);
      check("R8 quasi flag set", irq_flag, 4'b0100);
      irq_ack = 4'hF;
      step(1);
      irq_ack = 4'h0;
      check("R8 ack ignored by quasi flag", irq_flag, 4'b0100);
      flag_clr = 4'b0100;
      step(1);
      flag_clr = 4'b0000;
      check("R8 software clear", irq_flag, 4'b0000);

      // R11 mode writes under steady pins
      write_mode(2'd1, 4'd0);
      write_mode(2'd0, 4'd2);
      write_mode(2'd2, 4'd0);
      step(6);
      check("R11 no request from mode change", irq_flag, 4'b0000);

      // R5 filter on CPU clock, rising
      write_mode(2'd0, 4'd0);
      pin_in[0] = 1'b1;
      step(2);
      pin_in[0] = 1'b0;
      step(12);
      check("R5 two-sample glitch rejected", irq_flag, 4'b0000);
      pin_in[0] = 1'b1;
      step(3);
      pin_in[0] = 1'b0;
      step(12);
      check("R5 three-sample pulse accepted", irq_flag, 4'b0001);
      clear_all();

      // R6 divided sampling
      write_mode(2'd0, 4'b1000);
      pin_in[0] = 1'b1;
      step(6);
      pin_in[0] = 1'b0;
      step(40);
      check("R6 short pulse rejected at divided rate", irq_flag, 4'b0000);
      pin_in[0] = 1'b1;
      step(40);
      check("R6 long pulse accepted at divided rate", irq_flag, 4'b0001);
      pin_in[0] = 1'b0;
      step(40);
      clear_all();
      write_mode(2'd0, 4'b0000);
      pin_in[0] = 1'b1;
      step(6);
      pin_in[0] = 1'b0;
      step(12);
      check("R6 short pulse accepted at CPU rate", irq_flag, 4'b0001);
      clear_all();

      // R12 select 3 writes nothing
      write_mode(2'd3, 4'hF);
      pin_in[0] = 1'b1;
      pin_in[1] = 1'b1;
      step(12);
      check("R12 select 3 left modes unchanged", irq_flag, 4'b0011);

      finish_run();
   end
endmodule